// File: doc/BRIEF.md
# Bit-Serial Dynamic Memory Storage Controller

This block records and replays single-bit streams in external one-bit-wide dynamic RAM. It serves two channels at once. The speech channel carries a delta-modulation bit stream: each codec bit strobe writes one bit when recording, or fetches one bit when playing. The data channel is filled or drained one bit per strobe by a host register interface. Each channel is loaded with a begin pointer and an end pointer. It then walks a current pointer from the begin pointer up to the end pointer, both included, and afterwards raises a sticky done flag and stops.

One sequencer drives the shared memory pins: a multiplexed row/column address bus, one row strobe per memory section, one column strobe and a write enable. A refresh timer requests a CAS-before-RAS cycle at a fixed interval, so no refresh address is kept. An arbiter serves refresh first, then speech, then data. A density input selects 1 Mbit devices (10 address lines) or 256 Kbit devices (9 lines, top line held low). Row and column share one split of the linear pointer on the same pins, so the board may wire the address lines to the memory in any order. A bypass input stops all new memory activity and routes the codec bit and its strobe straight to two pins.

Top module: `bsdram_ctrl`

## Requirements
- R1: After reset all row strobes, the column strobe and the write enable are high (inactive), both done flags are 0 and both bypass pins are 0.
- R2: Bits recorded by the speech channel over a range are returned in the same order when that range is played back, also across row and section boundaries.
- R3: The data channel records and plays back correctly while the speech channel is active at the same time.
- R4: With 1 Mbit devices (density input 1), a pointer p goes to section p[21:20], row p[19:10] and column p[9:0]. Row and column appear on the same address pins.
- R5: With 256 Kbit devices (density input 0), a pointer p goes to section p[19:18], row p[17:9] and column p[8:0]. Address pin 9 stays 0 in both phases.
- R6: A channel performs exactly end-begin+1 accesses and then raises its done flag. Later strobes perform no memory access, and done stays 1 until the next start.
- R7: A refresh takes place once every REF_DIV clock cycles. In it the column strobe falls while all row strobes are high, and then all row strobes fall together.
- R8: Refresh is served before speech, and speech before data. When speech and data strobe in the same cycle, the speech bit is written first.
- R9: No row strobe stays low for more than RAS_MAX_CYC consecutive cycles (25 cycles, 200 ns at 125 MHz).
- R10: While bypass is 1, no row strobe falls. dir_bit equals sp_din and dir_clk equals sp_stb. Both pins are 0 while bypass is 0.
- R11: A read or write access drives exactly one row strobe low. The write enable is low only while one row strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bypass | input | 1 | 1: no-memory mode, codec signals routed to pins |
| cfg_big | input | 1 | 1: 1 Mbit devices, 0: 256 Kbit devices |
| sp_start | input | 1 | Load speech pointers and begin a run |
| sp_rec | input | 1 | Speech direction at start: 1 record, 0 play |
| sp_beg | input | 22 | Speech begin pointer |
| sp_end | input | 22 | Speech end pointer (inclusive) |
| sp_stb | input | 1 | Codec bit strobe |
| sp_din | input | 1 | Codec bit to record |
| sp_dout | output | 1 | Played speech bit |
| sp_done | output | 1 | Speech run finished |
| dt_start | input | 1 | Load data pointers and begin a run |
| dt_rec | input | 1 | Data direction at start: 1 store, 0 retrieve |
| dt_beg | input | 22 | Data begin pointer |
| dt_end | input | 22 | Data end pointer (inclusive) |
| dt_stb | input | 1 | Host bit strobe |
| dt_din | input | 1 | Host bit to store |
| dt_dout | output | 1 | Retrieved data bit |
| dt_done | output | 1 | Data run finished |
| mem_addr | output | 10 | Multiplexed row/column address |
| mem_ras_n | output | 4 | Row strobe per section, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_d | output | 1 | Write data to memory |
| mem_q | input | 1 | Read data from memory |
| dir_bit | output | 1 | Bypass codec bit |
| dir_clk | output | 1 | Bypass codec strobe |

## Verification
The bench builds the controller with REF_DIV = 97 and T_PH = 2. A refresh then falls every few speech bits, so refresh, speech and data requests collide often. Within a few thousand cycles this reaches the priority order, the ten-cycle access stretched behind a refresh, and the row-strobe width limit. The memory model swaps the address pins in a fixed order in both phases. Its test ranges cross row and section boundaries in both densities, so any mismatch between the pointer split and the pin order shows up as a wrong bit on play-back.

// File: rtl/bsdram_pkg.sv
package bsdram_pkg;
  localparam int N_SRC  = 3;
  localparam int SRC_REF = 0;
  localparam int SRC_SP  = 1;
  localparam int SRC_DT  = 2;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_ADDR,
    SQ_RAS,
    SQ_COL,
    SQ_CAS,
    SQ_RF1,
    SQ_RF2,
    SQ_RF3,
    SQ_PRE
  } seq_st_e;
endpackage

// File: rtl/bsd_reftmr.sv
module bsd_reftmr #(
  parameter int REF_DIV = 1950,
  localparam int CW = (REF_DIV > 2) ? $clog2(REF_DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic req
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(REF_DIV - 1));

  always_comb begin
    cnt_d  = wrap ? '0 : cnt_q + CW'(1);
    pend_d = pend_q;
    if (ack)  pend_d = 1'b0;
    if (wrap) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign req = pend_q;
endmodule

// File: rtl/bsd_arb.sv
module bsd_arb import bsdram_pkg::*; (
  input  logic             en,
  input  logic [N_SRC-1:0] req,
  output logic [N_SRC-1:0] gnt
);
  always_comb begin
    gnt = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (en && req[i] && (gnt == '0)) gnt[i] = 1'b1;
    end
  end
endmodule

// File: rtl/bsd_chan.sv
module bsd_chan #(
  parameter int PW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rec_in,
  input  logic [PW-1:0] beg,
  input  logic [PW-1:0] fin,
  input  logic          stb,
  input  logic          din,
  input  logic          ack,
  input  logic          rdata,
  output logic          req,
  output logic          rec,
  output logic [PW-1:0] cur,
  output logic          wbit,
  output logic          dout,
  output logic          done
);
  logic          busy_q, busy_d;
  logic          rec_q, rec_d;
  logic [PW-1:0] cur_q, cur_d, end_q, end_d;
  logic          req_q, req_d, wbit_q, wbit_d, dout_q, dout_d, done_q, done_d;

  always_comb begin
    busy_d = busy_q;
    rec_d  = rec_q;
    cur_d  = cur_q;
    end_d  = end_q;
    req_d  = req_q;
    wbit_d = wbit_q;
    dout_d = dout_q;
    done_d = done_q;
    if (start) begin
      busy_d = 1'b1;
      rec_d  = rec_in;
      cur_d  = beg;
      end_d  = fin;
      req_d  = 1'b0;
      done_d = 1'b0;
    end else begin
      if (busy_q && stb && !req_q) begin
        req_d  = 1'b1;
        wbit_d = din;
      end
      if (ack) begin
        req_d = 1'b0;
        if (!rec_q) dout_d = rdata;
        if (cur_q == end_q) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          cur_d = cur_q + PW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rec_q  <= 1'b0;
      cur_q  <= '0;
      end_q  <= '0;
      req_q  <= 1'b0;
      wbit_q <= 1'b0;
      dout_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      rec_q  <= rec_d;
      cur_q  <= cur_d;
      end_q  <= end_d;
      req_q  <= req_d;
      wbit_q <= wbit_d;
      dout_q <= dout_d;
      done_q <= done_d;
    end
  end

  assign req  = req_q;
  assign rec  = rec_q;
  assign cur  = cur_q;
  assign wbit = wbit_q;
  assign dout = dout_q;
  assign done = done_q;
endmodule

// File: rtl/bsd_seq.sv
module bsd_seq import bsdram_pkg::*; #(
  parameter int AP    = 10,
  parameter int SEC_N = 4,
  parameter int T_PH  = 2,
  localparam int SEC_W = $clog2(SEC_N),
  localparam int PH_W  = (T_PH > 1) ? $clog2(T_PH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bypass,
  input  logic [N_SRC-1:0] gnt,
  input  logic [SEC_W-1:0] sec_in,
  input  logic [AP-1:0]    row_in,
  input  logic [AP-1:0]    col_in,
  input  logic             wr_in,
  input  logic             wd_in,
  input  logic             mem_q,
  output logic             idle,
  output logic [AP-1:0]    mem_addr,
  output logic [SEC_N-1:0] ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic             mem_d,
  output logic [N_SRC-1:0] ack,
  output logic             rdata
);
  seq_st_e          st_q, st_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic [N_SRC-1:0] src_q, src_d;
  logic [SEC_W-1:0] sec_q, sec_d;
  logic [AP-1:0]    row_q, row_d, col_q, col_d;
  logic             wr_q, wr_d, wd_q, wd_d;
  logic [AP-1:0]    addr_q, addr_d;
  logic [SEC_N-1:0] ras_q, ras_d;
  logic             cas_q, cas_d, we_q, we_d, md_q, md_d;
  logic [N_SRC-1:0] ack_q, ack_d;
  logic             rd_q, rd_d;
  logic             ph_last;

  assign ph_last = (ph_q == PH_W'(T_PH - 1));

  // next state
  always_comb begin
    st_d  = st_q;
    ph_d  = ph_q;
    src_d = src_q;
    sec_d = sec_q;
    row_d = row_q;
    col_d = col_q;
    wr_d  = wr_q;
    wd_d  = wd_q;
    ack_d = '0;
    rd_d  = rd_q;
    if (st_q == SQ_IDLE) begin
      if (gnt != '0) begin
        src_d = gnt;
        sec_d = sec_in;
        row_d = row_in;
        col_d = col_in;
        wr_d  = wr_in;
        wd_d  = wd_in;
        ph_d  = '0;
        st_d  = gnt[SRC_REF] ? SQ_RF1 : SQ_ADDR;
      end
    end else if (ph_last) begin
      ph_d = '0;
      case (st_q)
        SQ_ADDR: st_d = bypass ? SQ_PRE : SQ_RAS;
        SQ_RAS:  st_d = SQ_COL;
        SQ_COL:  st_d = SQ_CAS;
        SQ_CAS: begin
          st_d  = SQ_PRE;
          ack_d = src_q;
          rd_d  = mem_q;
        end
        SQ_RF1:  st_d = bypass ? SQ_PRE : SQ_RF2;
        SQ_RF2:  st_d = SQ_RF3;
        SQ_RF3: begin
          st_d  = SQ_PRE;
          ack_d = src_q;
        end
        default: st_d = SQ_IDLE;
      endcase
    end else begin
      ph_d = ph_q + PH_W'(1);
    end
  end

  // pin values for the coming state
  always_comb begin
    addr_d = '0;
    ras_d  = '1;
    cas_d  = 1'b1;
    we_d   = 1'b1;
    md_d   = 1'b0;
    case (st_d)
      SQ_ADDR: addr_d = row_d;
      SQ_RAS: begin
        addr_d = row_d;
        ras_d  = ~(SEC_N'(1) << sec_d);
      end
      SQ_COL: begin
        addr_d = col_d;
        ras_d  = ~(SEC_N'(1) << sec_d);
        we_d   = ~wr_d;
        md_d   = wd_d;
      end
      SQ_CAS: begin
        addr_d = col_d;
        ras_d  = ~(SEC_N'(1) << sec_d);
        cas_d  = 1'b0;
        we_d   = ~wr_d;
        md_d   = wd_d;
      end
      SQ_RF1: cas_d = 1'b0;
      SQ_RF2: begin
        cas_d = 1'b0;
        ras_d = '0;
      end
      SQ_RF3: ras_d = '0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      ph_q   <= '0;
      src_q  <= '0;
      sec_q  <= '0;
      row_q  <= '0;
      col_q  <= '0;
      wr_q   <= 1'b0;
      wd_q   <= 1'b0;
      addr_q <= '0;
      ras_q  <= '1;
      cas_q  <= 1'b1;
      we_q   <= 1'b1;
      md_q   <= 1'b0;
      ack_q  <= '0;
      rd_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      src_q  <= src_d;
      sec_q  <= sec_d;
      row_q  <= row_d;
      col_q  <= col_d;
      wr_q   <= wr_d;
      wd_q   <= wd_d;
      addr_q <= addr_d;
      ras_q  <= ras_d;
      cas_q  <= cas_d;
      we_q   <= we_d;
      md_q   <= md_d;
      ack_q  <= ack_d;
      rd_q   <= rd_d;
    end
  end

  assign idle     = (st_q == SQ_IDLE);
  assign mem_addr = addr_q;
  assign ras_n    = ras_q;
  assign cas_n    = cas_q;
  assign we_n     = we_q;
  assign mem_d    = md_q;
  assign ack      = ack_q;
  assign rdata    = rd_q;
endmodule

// File: rtl/bsdram_ctrl.sv
module bsdram_ctrl import bsdram_pkg::*; #(
  parameter int AP      = 10,
  parameter int SEC_N   = 4,
  parameter int REF_DIV = 1950,
  parameter int T_PH    = 2,
  localparam int SEC_W  = $clog2(SEC_N),
  localparam int PW     = SEC_W + 2 * AP,
  localparam int SW     = 2 * (AP - 1),
  localparam int N_CH   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_bypass,
  input  logic             cfg_big,
  input  logic             sp_start,
  input  logic             sp_rec,
  input  logic [PW-1:0]    sp_beg,
  input  logic [PW-1:0]    sp_end,
  input  logic             sp_stb,
  input  logic             sp_din,
  output logic             sp_dout,
  output logic             sp_done,
  input  logic             dt_start,
  input  logic             dt_rec,
  input  logic [PW-1:0]    dt_beg,
  input  logic [PW-1:0]    dt_end,
  input  logic             dt_stb,
  input  logic             dt_din,
  output logic             dt_dout,
  output logic             dt_done,
  output logic [AP-1:0]    mem_addr,
  output logic [SEC_N-1:0] mem_ras_n,
  output logic             mem_cas_n,
  output logic             mem_we_n,
  output logic             mem_d,
  input  logic             mem_q,
  output logic             dir_bit,
  output logic             dir_clk
);
  // reset: asserted at once, released on the clock
  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  logic [N_CH-1:0]  ch_start, ch_rec_in, ch_stb, ch_din, ch_req, ch_rec;
  logic [N_CH-1:0]  ch_wbit, ch_dout, ch_done, ch_ack;
  logic [PW-1:0]    ch_beg [N_CH];
  logic [PW-1:0]    ch_end [N_CH];
  logic [PW-1:0]    ch_cur [N_CH];
  logic [SEC_W-1:0] ch_sec [N_CH];
  logic [AP-1:0]    ch_row [N_CH];
  logic [AP-1:0]    ch_col [N_CH];

  assign ch_start  = {dt_start, sp_start};
  assign ch_rec_in = {dt_rec, sp_rec};
  assign ch_stb    = {dt_stb, sp_stb};
  assign ch_din    = {dt_din, sp_din};
  assign ch_beg[0] = sp_beg;
  assign ch_beg[1] = dt_beg;
  assign ch_end[0] = sp_end;
  assign ch_end[1] = dt_end;

  logic [N_SRC-1:0] arb_req, arb_gnt, seq_ack;
  logic             ref_req, seq_idle, seq_rdata;

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      bsd_chan #(.PW(PW)) u_chan (
        .clk    (clk),
        .rst_n  (rst_q),
        .start  (ch_start[c]),
        .rec_in (ch_rec_in[c]),
        .beg    (ch_beg[c]),
        .fin    (ch_end[c]),
        .stb    (ch_stb[c]),
        .din    (ch_din[c]),
        .ack    (ch_ack[c]),
        .rdata  (seq_rdata),
        .req    (ch_req[c]),
        .rec    (ch_rec[c]),
        .cur    (ch_cur[c]),
        .wbit   (ch_wbit[c]),
        .dout   (ch_dout[c]),
        .done   (ch_done[c])
      );

      // split of the linear pointer, same for both densities' pin order
      always_comb begin
        if (cfg_big) begin
          ch_sec[c] = ch_cur[c][PW-1 -: SEC_W];
          ch_row[c] = ch_cur[c][2*AP-1 : AP];
          ch_col[c] = ch_cur[c][AP-1 : 0];
        end else begin
          ch_sec[c] = ch_cur[c][SW+SEC_W-1 : SW];
          ch_row[c] = {1'b0, ch_cur[c][SW-1 : AP-1]};
          ch_col[c] = {1'b0, ch_cur[c][AP-2 : 0]};
        end
      end
    end
  endgenerate

  bsd_reftmr #(.REF_DIV(REF_DIV)) u_ref (
    .clk   (clk),
    .rst_n (rst_q),
    .ack   (seq_ack[SRC_REF]),
    .req   (ref_req)
  );

  assign arb_req = {ch_req[1], ch_req[0], ref_req};

  bsd_arb u_arb (
    .en  (seq_idle & ~cfg_bypass),
    .req (arb_req),
    .gnt (arb_gnt)
  );

  logic             sel_sp;
  logic [SEC_W-1:0] sel_sec;
  logic [AP-1:0]    sel_row, sel_col;
  logic             sel_wr, sel_wd;

  assign sel_sp  = arb_gnt[SRC_SP];
  assign sel_sec = sel_sp ? ch_sec[0]  : ch_sec[1];
  assign sel_row = sel_sp ? ch_row[0]  : ch_row[1];
  assign sel_col = sel_sp ? ch_col[0]  : ch_col[1];
  assign sel_wr  = sel_sp ? ch_rec[0]  : ch_rec[1];
  assign sel_wd  = sel_sp ? ch_wbit[0] : ch_wbit[1];

  bsd_seq #(.AP(AP), .SEC_N(SEC_N), .T_PH(T_PH)) u_seq (
    .clk      (clk),
    .rst_n    (rst_q),
    .bypass   (cfg_bypass),
    .gnt      (arb_gnt),
    .sec_in   (sel_sec),
    .row_in   (sel_row),
    .col_in   (sel_col),
    .wr_in    (sel_wr),
    .wd_in    (sel_wd),
    .mem_q    (mem_q),
    .idle     (seq_idle),
    .mem_addr (mem_addr),
    .ras_n    (mem_ras_n),
    .cas_n    (mem_cas_n),
    .we_n     (mem_we_n),
    .mem_d    (mem_d),
    .ack      (seq_ack),
    .rdata    (seq_rdata)
  );

  assign ch_ack  = {seq_ack[SRC_DT], seq_ack[SRC_SP]};
  assign sp_dout = ch_dout[0];
  assign dt_dout = ch_dout[1];
  assign sp_done = ch_done[0];
  assign dt_done = ch_done[1];
  assign dir_bit = cfg_bypass & sp_din;
  assign dir_clk = cfg_bypass & sp_stb;
endmodule

// File: rtl/bsdram_chk.sv
module bsdram_chk import bsdram_pkg::*; #(
  parameter int SEC_N       = 4,
  parameter int RAS_MAX_CYC = 25
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_bypass,
  input logic [SEC_N-1:0] mem_ras_n,
  input logic             mem_cas_n,
  input logic             mem_we_n,
  input logic [N_SRC-1:0] req,
  input logic [N_SRC-1:0] gnt
);
  logic [7:0] low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (mem_ras_n != '1) low_cnt <= (low_cnt == 8'hFF) ? low_cnt : low_cnt + 8'd1;
    else low_cnt <= '0;
  end

  AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(low_cnt) <= RAS_MAX_CYC)); // R9

  AST_SECTION_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (($countones(~mem_ras_n) <= 1) || (mem_ras_n == '0))); // R11

  AST_WE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> ($countones(~mem_ras_n) == 1)); // R11

  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_ras_n == '0) && ($past(mem_ras_n) == '1)) |-> $past(!mem_cas_n)); // R7

  AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bypass && $past(cfg_bypass)) |-> ((mem_ras_n | ~$past(mem_ras_n)) == '1)); // R10

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == '0)); // R8

  AST_REF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[SRC_SP] || gnt[SRC_DT]) |-> !req[SRC_REF]); // R8

  AST_SP_BEFORE_DT: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[SRC_DT] |-> !req[SRC_SP]); // R8
endmodule

bind bsdram_ctrl bsdram_chk #(.SEC_N(SEC_N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q),
  .cfg_bypass (cfg_bypass),
  .mem_ras_n  (mem_ras_n),
  .mem_cas_n  (mem_cas_n),
  .mem_we_n   (mem_we_n),
  .req        (arb_req),
  .gnt        (arb_gnt)
);

// File: tb/bsdram_ctrl_tb.sv
module bsdram_ctrl_tb;
  localparam int AP      = 10;
  localparam int SEC_N   = 4;
  localparam int PW      = 22;
  localparam int REF_DIV = 97;
  localparam int T_PH    = 2;
  localparam int GAP     = 36;

  logic clk, rst_n, cfg_bypass, cfg_big;
  logic sp_start, sp_rec, sp_stb, sp_din, sp_dout, sp_done;
  logic dt_start, dt_rec, dt_stb, dt_din, dt_dout, dt_done;
  logic [PW-1:0] sp_beg, sp_end, dt_beg, dt_end;
  logic [AP-1:0] mem_addr;
  logic [SEC_N-1:0] mem_ras_n;
  logic mem_cas_n, mem_we_n, mem_d, mem_q, dir_bit, dir_clk;

  int nchk, nfail;

  bsdram_ctrl #(.AP(AP), .SEC_N(SEC_N), .REF_DIV(REF_DIV), .T_PH(T_PH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_bypass(cfg_bypass), .cfg_big(cfg_big),
    .sp_start(sp_start), .sp_rec(sp_rec), .sp_beg(sp_beg), .sp_end(sp_end),
    .sp_stb(sp_stb), .sp_din(sp_din), .sp_dout(sp_dout), .sp_done(sp_done),
    .dt_start(dt_start), .dt_rec(dt_rec), .dt_beg(dt_beg), .dt_end(dt_end),
    .dt_stb(dt_stb), .dt_din(dt_din), .dt_dout(dt_dout), .dt_done(dt_done),
    .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_we_n(mem_we_n), .mem_d(mem_d), .mem_q(mem_q),
    .dir_bit(dir_bit), .dir_clk(dir_clk)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---------------- memory model (address pins wired in a scrambled order)
  bit          mem [int];
  logic [3:0]  ras_prev, fall;
  logic        cas_prev;
  logic [9:0]  row_lat;
  int          sec_lat, key;
  int          ref_cnt, wcount, rfall_cnt, err_cbr, err_excl, rlow, rlow_max;
  int          lg_sec [$];
  logic [9:0]  lg_row [$];
  logic [9:0]  lg_col [$];

  function automatic logic [9:0] perm(input logic [9:0] a);
    logic [9:0] r;
    for (int i = 0; i < 10; i++) r[(i * 3 + 1) % 10] = a[i];
    return r;
  endfunction

  always @(posedge clk) begin
    #2;
    if (!rst_n) begin
      ras_prev = '1; cas_prev = 1'b1; rlow = 0; mem_q = 1'b0;
    end else begin
      fall = ras_prev & ~mem_ras_n;
      if (fall != '0) begin
        rfall_cnt++;
        if (!mem_cas_n) begin
          ref_cnt++;
          if (mem_ras_n != '0) err_cbr++;
        end else begin
          if ($countones(fall) != 1) err_excl++;
          row_lat = mem_addr;
          for (int s = 0; s < SEC_N; s++) if (fall[s]) sec_lat = s;
        end
      end
      if (cas_prev && !mem_cas_n && (mem_ras_n != '1)) begin
        key = (sec_lat << 20) | (int'(perm(row_lat)) << 10) | int'(perm(mem_addr));
        if (!mem_we_n) begin
          mem[key] = mem_d;
          wcount++;
          lg_sec.push_back(sec_lat);
          lg_row.push_back(row_lat);
          lg_col.push_back(mem_addr);
        end else begin
          mem_q = mem.exists(key) ? mem[key] : 1'b0;
        end
      end
      if (($countones(~mem_ras_n) > 1) && (mem_ras_n != '0)) err_excl++;
      if (mem_ras_n != '1) rlow++; else rlow = 0;
      if (rlow > rlow_max) rlow_max = rlow;
      ras_prev = mem_ras_n;
      cas_prev = mem_cas_n;
    end
  end

  // ---------------- helpers
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic pat(input int seed, input int i);
    return logic'(((i * 37 + seed * 11) >> 2) & 1);
  endfunction

  task automatic start2(input bit do_sp, input bit sp_r, input logic [PW-1:0] sb, input logic [PW-1:0] se,
                        input bit do_dt, input bit dt_r, input logic [PW-1:0] db, input logic [PW-1:0] de);
    @(negedge clk);
    sp_start = do_sp; sp_rec = sp_r; sp_beg = sb; sp_end = se;
    dt_start = do_dt; dt_rec = dt_r; dt_beg = db; dt_end = de;
    @(negedge clk);
    sp_start = 1'b0; dt_start = 1'b0;
  endtask

  task automatic strobe(input bit s, input bit d, input logic bs, input logic bd);
    @(negedge clk);
    sp_stb = s; sp_din = bs; dt_stb = d; dt_din = bd;
    @(negedge clk);
    sp_stb = 1'b0; dt_stb = 1'b0;
    repeat (GAP) @(negedge clk);
  endtask

  // count log entries whose fields differ from the pointer split
  function automatic int map_err(input int w0, input logic [PW-1:0] b, input int n, input bit big);
    int e = 0;
    for (int i = 0; i < n; i++) begin
      logic [PW-1:0] p = b + PW'(i);
      int es; logic [9:0] er, ec;
      if (big) begin es = int'(p[21:20]); er = p[19:10]; ec = p[9:0]; end
      else begin es = int'(p[19:18]); er = {1'b0, p[17:9]}; ec = {1'b0, p[8:0]}; end
      if ((w0 + i) >= lg_sec.size()) e++;
      else if (lg_sec[w0+i] != es || lg_row[w0+i] != er || lg_col[w0+i] != ec) e++;
    end
    return e;
  endfunction

  // ---------------- scenarios
  task automatic t_reset;
    @(negedge clk);
    chk(mem_ras_n == '1, "R1 ras_n", int'(mem_ras_n), 15);
    chk(mem_cas_n && mem_we_n, "R1 cas_n/we_n", int'({mem_cas_n, mem_we_n}), 3);
    chk(!sp_done && !dt_done, "R1 done", int'({sp_done, dt_done}), 0);
    chk(!dir_bit && !dir_clk, "R1 dir pins", int'({dir_bit, dir_clk}), 0);
  endtask

  task automatic t_big_speech;
    logic [PW-1:0] b = 22'h0FFFF4;
    int n = 24, w0, bad = 0;
    cfg_big = 1'b1;
    start2(1, 1, b, b + PW'(n - 1), 0, 0, '0, '0);
    w0 = wcount;
    for (int i = 0; i < n; i++) strobe(1, 0, pat(1, i), 1'b0);
    chk(wcount - w0 == n, "R6 write count", wcount - w0, n);
    chk(sp_done, "R6 done after range", int'(sp_done), 1);
    chk(map_err(w0, b, n, 1) == 0, "R4 pointer split 1M", map_err(w0, b, n, 1), 0);
    start2(1, 0, b, b + PW'(n - 1), 0, 0, '0, '0);
    for (int i = 0; i < n; i++) begin
      strobe(1, 0, 1'b0, 1'b0);
      if (sp_dout != pat(1, i)) bad++;
    end
    chk(bad == 0, "R2 speech play-back", bad, 0);
  endtask

  task automatic t_concurrent;
    logic [PW-1:0] a = 22'h2FF3F0, d = 22'h1003F8;
    int n = 20, w0, bs = 0, bd = 0;
    cfg_big = 1'b1;
    start2(1, 1, a, a + PW'(n - 1), 1, 1, d, d + PW'(n - 1));
    w0 = wcount;
    for (int i = 0; i < n; i++) strobe(1, 1, pat(2, i), pat(3, i));
    chk(map_err(w0, a, 1, 1) == 0, "R8 speech written first", lg_sec.size() > w0 ? lg_sec[w0] : -1, 2);
    chk(wcount - w0 == 2 * n, "R3 concurrent write count", wcount - w0, 2 * n);
    start2(1, 0, a, a + PW'(n - 1), 1, 0, d, d + PW'(n - 1));
    for (int i = 0; i < n; i++) begin
      strobe(1, 1, 1'b0, 1'b0);
      if (sp_dout != pat(2, i)) bs++;
      if (dt_dout != pat(3, i)) bd++;
    end
    chk(bs == 0, "R2 speech under data traffic", bs, 0);
    chk(bd == 0, "R3 data under speech traffic", bd, 0);
  endtask

  task automatic t_small;
    logic [PW-1:0] b = 22'h03FFF6;
    int n = 20, w0, bad = 0, hi = 0;
    cfg_big = 1'b0;
    start2(0, 0, '0, '0, 1, 1, b, b + PW'(n - 1));
    w0 = wcount;
    for (int i = 0; i < n; i++) strobe(0, 1, 1'b0, pat(4, i));
    chk(map_err(w0, b, n, 0) == 0, "R5 pointer split 256K", map_err(w0, b, n, 0), 0);
    for (int i = w0; i < lg_row.size(); i++) if (lg_row[i][9] || lg_col[i][9]) hi++;
    chk(hi == 0, "R5 pin 9 low", hi, 0);
    start2(0, 0, '0, '0, 1, 0, b, b + PW'(n - 1));
    for (int i = 0; i < n; i++) begin
      strobe(0, 1, 1'b0, 1'b0);
      if (dt_dout != pat(4, i)) bad++;
    end
    chk(bad == 0, "R5 256K play-back", bad, 0);
  endtask

  task automatic t_end_stop;
    logic [PW-1:0] b = 22'h000100;
    int w0;
    cfg_big = 1'b1;
    start2(0, 0, '0, '0, 1, 1, b, b + PW'(2));
    for (int i = 0; i < 3; i++) strobe(0, 1, 1'b0, 1'b1);
    chk(dt_done, "R6 done at end pointer", int'(dt_done), 1);
    w0 = wcount;
    for (int i = 0; i < 3; i++) strobe(0, 1, 1'b0, 1'b0);
    chk(wcount == w0, "R6 strobes after done ignored", wcount - w0, 0);
    chk(dt_done, "R6 done held", int'(dt_done), 1);
  endtask

  task automatic t_refresh;
    int r0 = ref_cnt;
    repeat (20 * REF_DIV) @(negedge clk);
    chk((ref_cnt - r0 >= 19) && (ref_cnt - r0 <= 21), "R7 refresh rate", ref_cnt - r0, 20);
    chk(err_cbr == 0, "R7 all sections in refresh", err_cbr, 0);
    chk(err_excl == 0, "R11 one section per access", err_excl, 0);
    chk(rlow_max > 0 && rlow_max <= 25, "R9 row strobe width", rlow_max, 25);
  endtask

  task automatic t_bypass;
    int f0, w0, bad = 0;
    @(negedge clk); cfg_bypass = 1'b1;
    repeat (20) @(negedge clk);
    f0 = rfall_cnt; w0 = wcount;
    start2(1, 1, 22'h000200, 22'h000210, 0, 0, '0, '0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); sp_stb = 1'b1; sp_din = pat(5, i);
      #1; if (dir_clk !== 1'b1 || dir_bit !== pat(5, i)) bad++;
      @(negedge clk); sp_stb = 1'b0; sp_din = ~pat(5, i);
      #1; if (dir_clk !== 1'b0 || dir_bit !== ~pat(5, i)) bad++;
    end
    chk(bad == 0, "R10 codec routed to pins", bad, 0);
    repeat (3 * REF_DIV) @(negedge clk);
    chk(rfall_cnt == f0 && wcount == w0, "R10 strobes quiet", rfall_cnt - f0, 0);
    @(negedge clk); cfg_bypass = 1'b0; sp_din = 1'b1;
    #1;
    chk(!dir_bit && !dir_clk, "R10 pins low outside bypass", int'({dir_bit, dir_clk}), 0);
    repeat (60) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    nchk = 0; nfail = 0;
    ref_cnt = 0; wcount = 0; rfall_cnt = 0; err_cbr = 0; err_excl = 0; rlow = 0; rlow_max = 0;
    sec_lat = 0; row_lat = '0; ras_prev = '1; cas_prev = 1'b1; mem_q = 1'b0;
    rst_n = 1'b0; cfg_bypass = 1'b0; cfg_big = 1'b1;
    sp_start = 0; sp_rec = 0; sp_beg = '0; sp_end = '0; sp_stb = 0; sp_din = 0;
    dt_start = 0; dt_rec = 0; dt_beg = '0; dt_end = '0; dt_stb = 0; dt_din = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_big_speech;
    t_concurrent;
    t_small;
    t_end_stop;
    t_refresh;
    t_bypass;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule